// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a large set of maskable peripheral request lines and a small set of non-maskable trap lines into one interrupt request toward a processor. Along with the request it reports which vector won and the program-memory address of that vector's slot, so the processor can fetch the handler address without further decoding.

Each maskable line has a sticky pending flag, an enable bit and a 3-bit priority level. A source can win only when its level is strictly above the processor's current level. Among the eligible sources the highest level wins, and a tie goes to the lower vector number. Trap lines ignore enables and the processor level, and they outrank every maskable source. The processor acknowledges the reported vector. The acknowledge clears that vector's pending flag and opens a one-cycle gap in the request, after which the next winner appears.

All pending flags are registered, and a balanced comparison tree feeds one output register. The latency from a request line to the outputs is therefore the same at any source count.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request line that is high at one rising edge sets its pending flag at that edge. The resulting `irqReq`, `irqVec` and `irqAddr` appear after the next rising edge, so the latency is two edges. Changes to enables, priorities or `cpuLevel` take effect at the next edge.
- R2: A maskable source is eligible only when its pending flag is set, its enable bit is 1, and its priority is strictly greater than `cpuLevel`. A priority of 0 therefore never requests.
- R3: Among eligible maskable sources the highest priority wins. On equal priority the lower vector number wins.
- R4: A pending trap is eligible regardless of `cpuLevel` or any enable, and it beats every maskable source. Among traps the lower trap index wins.
- R5: Trap t reports vector t. Maskable source i (bit i of `srcReq`) reports vector NUM_TRAP+i.
- R6: While `irqReq` is 1, `irqAddr` equals 4 + 2*`irqVec`. While `irqReq` is 0, both `irqVec` and `irqAddr` are 0.
- R7: A pending flag stays set after its request line falls, and it stays set until the flag is acknowledged.
- R8: `irqAck` sampled with `irqReq` at 1 clears the pending flag of the reported vector at that edge and forces `irqReq` to 0 for the following cycle. `irqAck` sampled with `irqReq` at 0 has no effect.
- R9: If an acknowledge and a new request on the same line arrive at the same edge, the flag remains set, and the source is reported again after the gap.
- R10: While `rstN` is low, all pending flags and all outputs are 0. Requests seen during reset are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| srcReq | input | NUM_SRC | Maskable request lines; a high level sets the pending flag |
| srcEn | input | NUM_SRC | Per-source enable |
| srcPrio | input | 3*NUM_SRC | Per-source priority; bits [3i+2:3i] belong to source i |
| trapReq | input | NUM_TRAP | Non-maskable trap request lines |
| cpuLevel | input | 3 | Current processor priority level |
| irqAck | input | 1 | Processor accepts the reported vector |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVec | output | clog2(NUM_SRC+NUM_TRAP) | Winning vector number |
| irqAddr | output | ADDR_W | Program address of the winning vector slot |

## Verification
The delicate cycle is the one in which an acknowledge clears a pending flag while a fresh request on the same line sets it again. The bench provokes this for both a maskable source and a trap. It checks that `irqReq` drops for exactly one cycle and that the same vector returns afterwards. Every acknowledge, whether issued in a random sweep or during draining, is judged against a bench model that applies clear-then-set to its own pending copy and recomputes the winner from the priority rules.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W     = 3;
  localparam int VEC_MAX_W = 8;   // supports up to 256 vectors
  localparam int KEY_W     = LVL_W + 2;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic                 clrPend;
    logic [VEC_MAX_W-1:0] clrVec;
  } ackStrobe_t;
endpackage

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC  = 114,
  parameter int NUM_TRAP = 7,
  parameter int VEC_W    = $clog2(NUM_SRC + NUM_TRAP)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SRC-1:0]     srcReq,
  input  logic [NUM_SRC-1:0]     srcEn,
  input  logic [NUM_SRC*LVL_W-1:0] srcPrio,
  input  logic [NUM_TRAP-1:0]    trapReq,
  input  logic [LVL_W-1:0]       cpuLevel,
  input  ackStrobe_t             strobe,
  output logic                   rootValid,
  output logic [VEC_W-1:0]       rootIdx
);
  localparam int TOTAL  = NUM_SRC + NUM_TRAP;
  localparam int LEAVES = 1 << VEC_W;

  logic [NUM_SRC-1:0]  srcPend;
  logic [NUM_TRAP-1:0] trapPend;
  logic [TOTAL-1:0]    clrMask;
  logic [TOTAL-1:0]    allPend;
  logic [TOTAL-1:0]    allReq;

  assign allPend = {srcPend, trapPend};
  assign allReq  = {srcReq, trapReq};

  always_comb begin
    for (int k = 0; k < TOTAL; k++)
      clrMask[k] = strobe.clrPend && (strobe.clrVec == VEC_MAX_W'(k));
  end

  // Pending flags: clear on acknowledge, then set by a request (set wins).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPend  <= '0;
      trapPend <= '0;
    end else begin
      trapPend <= (trapPend & ~clrMask[NUM_TRAP-1:0]) | trapReq;
      srcPend  <= (srcPend & ~clrMask[TOTAL-1:NUM_TRAP]) | srcReq;
    end
  end

  // Heap-ordered comparison tree. Key = {eligible, isTrap, level}.
  logic [KEY_W-1:0] nodeKey [1:2*LEAVES-1];
  logic [VEC_W-1:0] nodeIdx [1:2*LEAVES-1];

  genvar g, n;
  generate
    for (g = 0; g < LEAVES; g++) begin : gLeaf
      if (g < NUM_TRAP) begin : gTrap
        assign nodeKey[LEAVES+g] = {trapPend[g], 1'b1, {LVL_W{1'b0}}};
      end else if (g < TOTAL) begin : gSrc
        logic [LVL_W-1:0] lvl;
        assign lvl = srcPrio[(g-NUM_TRAP)*LVL_W +: LVL_W];
        assign nodeKey[LEAVES+g] =
          {srcPend[g-NUM_TRAP] & srcEn[g-NUM_TRAP] & (lvl > cpuLevel), 1'b0, lvl};
      end else begin : gPad
        assign nodeKey[LEAVES+g] = '0;
      end
      assign nodeIdx[LEAVES+g] = VEC_W'(g);
    end

    for (n = 1; n < LEAVES; n++) begin : gNode
      logic pickRight;
      // Right child only wins when strictly better: ties keep the lower vector.
      assign pickRight  = nodeKey[2*n+1] > nodeKey[2*n];
      assign nodeKey[n] = pickRight ? nodeKey[2*n+1] : nodeKey[2*n];
      assign nodeIdx[n] = pickRight ? nodeIdx[2*n+1] : nodeIdx[2*n];
    end
  endgenerate

  assign rootValid = nodeKey[1][KEY_W-1];
  assign rootIdx   = nodeIdx[1];

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(allPend) & ~$past(clrMask) & ~allPend) == '0)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPend && !allReq[strobe.clrVec[VEC_W-1:0]]
      |=> !allPend[$past(strobe.clrVec[VEC_W-1:0])]); // R8
  AST_REQ_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrPend && allReq[strobe.clrVec[VEC_W-1:0]]
      |=> allPend[$past(strobe.clrVec[VEC_W-1:0])]); // R9
  AST_TRAP_OUTRANKS: assert property (@(posedge clk) disable iff (!rstN)
    rootValid && int'(rootIdx) >= NUM_TRAP |-> trapPend == '0); // R4
endmodule

// File: rtl/prio_irq_control.sv
module prio_irq_control
  import prio_irq_pkg::*;
#(
  parameter int VEC_W     = 7,
  parameter int ADDR_W    = 24,
  parameter int ADDR_BASE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rootValid,
  input  logic [VEC_W-1:0]  rootIdx,
  input  logic              irqAck,
  output ackStrobe_t        strobe,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVec,
  output logic [ADDR_W-1:0] irqAddr
);
  logic ackValid;

  assign ackValid       = irqAck && irqReq;
  assign strobe.clrPend = ackValid;
  assign strobe.clrVec  = VEC_MAX_W'(irqVec);

  // Output stage: one register after the tree; an accepted acknowledge
  // inserts a one-cycle gap so the stale winner is never offered twice.
  always_ff @(posedge clk) begin
    if (!rstN || ackValid) begin
      irqReq  <= 1'b0;
      irqVec  <= '0;
      irqAddr <= '0;
    end else begin
      irqReq  <= rootValid;
      irqVec  <= rootValid ? rootIdx : '0;
      irqAddr <= rootValid ? ADDR_W'(ADDR_BASE) + (ADDR_W'(rootIdx) << 1) : '0;
    end
  end

  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    irqAck && irqReq |=> !irqReq); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && $past(irqReq) && irqVec == $past(irqVec) + 1'b1
      |-> irqAddr == $past(irqAddr) + ADDR_W'(2)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 114,
  parameter int NUM_TRAP  = 7,
  parameter int ADDR_W    = 24,
  parameter int ADDR_BASE = 4,
  localparam int VEC_W    = $clog2(NUM_SRC + NUM_TRAP)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcReq,
  input  logic [NUM_SRC-1:0]         srcEn,
  input  logic [NUM_SRC*LVL_W-1:0]   srcPrio,
  input  logic [NUM_TRAP-1:0]        trapReq,
  input  logic [LVL_W-1:0]           cpuLevel,
  input  logic                       irqAck,
  output logic                       irqReq,
  output logic [VEC_W-1:0]           irqVec,
  output logic [ADDR_W-1:0]          irqAddr
);
  ackStrobe_t       strobe;
  logic             rootValid;
  logic [VEC_W-1:0] rootIdx;

  prio_irq_datapath #(.NUM_SRC(NUM_SRC), .NUM_TRAP(NUM_TRAP), .VEC_W(VEC_W)) uData (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .srcPrio(srcPrio),
    .trapReq(trapReq), .cpuLevel(cpuLevel), .strobe(strobe),
    .rootValid(rootValid), .rootIdx(rootIdx)
  );

  prio_irq_control #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .rootValid(rootValid), .rootIdx(rootIdx),
    .irqAck(irqAck), .strobe(strobe),
    .irqReq(irqReq), .irqVec(irqVec), .irqAddr(irqAddr)
  );

  function automatic logic [LVL_W-1:0] prioAt(input logic [NUM_SRC*LVL_W-1:0] p, input int k);
    return p[k*LVL_W +: LVL_W];
  endfunction

  function automatic logic bitAt(input logic [NUM_SRC-1:0] v, input int k);
    return v[k];
  endfunction

  AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && int'(irqVec) >= NUM_TRAP
      |-> prioAt($past(srcPrio), int'(irqVec) - NUM_TRAP) > $past(cpuLevel)
          && bitAt($past(srcEn), int'(irqVec) - NUM_TRAP)); // R2
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  localparam int NS = 8;
  localparam int NT = 3;
  localparam int TOT = NS + NT;
  localparam int VW = $clog2(TOT);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcReq = '0;
  logic [NS-1:0] srcEn = '0;
  logic [NS*3-1:0] srcPrio = '0;
  logic [NT-1:0] trapReq = '0;
  logic [2:0] cpuLevel = '0;
  logic irqAck = 1'b0;
  logic irqReq;
  logic [VW-1:0] irqVec;
  logic [23:0] irqAddr;

  int nChecks = 0;
  int nFail = 0;
  bit [TOT-1:0] mPend = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS), .NUM_TRAP(NT)) uut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .srcPrio(srcPrio),
    .trapReq(trapReq), .cpuLevel(cpuLevel), .irqAck(irqAck),
    .irqReq(irqReq), .irqVec(irqVec), .irqAddr(irqAddr)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic void model(output bit f, output int v);
    int bp;
    f = 0; v = 0; bp = 0;
    for (int t = 0; t < NT; t++)
      if (mPend[t]) begin f = 1; v = t; return; end
    for (int i = 0; i < NS; i++) begin
      int p;
      p = int'(srcPrio[i*3 +: 3]);
      if (mPend[NT+i] && srcEn[i] && p > int'(cpuLevel) && (!f || p > bp)) begin
        f = 1; v = NT + i; bp = p;
      end
    end
  endfunction

  task automatic checkOut(input string r);
    bit f; int v;
    model(f, v);
    chk(r, "irqReq", int'(irqReq), int'(f));
    chk(r, "irqVec", int'(irqVec), f ? v : 0);
    chk(r, "irqAddr", int'(irqAddr), f ? 4 + 2*v : 0);
  endtask

  task automatic applyReq(input logic [NS-1:0] s, input logic [NT-1:0] t, input string r);
    @(negedge clk);
    srcReq = s; trapReq = t;
    mPend = mPend | {s, t};
    @(negedge clk);
    srcReq = '0; trapReq = '0;
    @(negedge clk);
    checkOut(r);
  endtask

  task automatic ackOnce(input bit again, input string r);
    int v;
    v = int'(irqVec);
    irqAck = 1'b1;
    if (again) begin
      if (v < NT) trapReq[v] = 1'b1; else srcReq[v-NT] = 1'b1;
    end
    mPend[v] = again;
    @(negedge clk);
    irqAck = 1'b0; srcReq = '0; trapReq = '0;
    chk("R8", "gap irqReq", int'(irqReq), 0);
    @(negedge clk);
    checkOut(r);
  endtask

  task automatic drain();
    srcEn = '1;
    srcPrio = {NS{3'd7}};
    cpuLevel = 3'd0;
    @(negedge clk);
    checkOut("R3,R4 drain");
    for (int k = 0; k < TOT + 2; k++) begin
      if (!irqReq) break;
      ackOnce(1'b0, "R3,R4,R5 drain order");
    end
    chk("R7", "pending left after drain", int'(mPend != '0), 0);
  endtask

  task automatic step();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    // R10: reset clears outputs and discards requests seen during reset
    srcReq = '1; trapReq = '1; srcEn = '1; srcPrio = {NS{3'd7}};
    repeat (3) @(negedge clk);
    chk("R10", "irqReq in reset", int'(irqReq), 0);
    chk("R10", "irqVec in reset", int'(irqVec), 0);
    chk("R10", "irqAddr in reset", int'(irqAddr), 0);
    srcReq = '0; trapReq = '0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "irqReq after reset", int'(irqReq), 0);

    // R1: two-edge latency
    srcEn = '1; cpuLevel = 0; srcPrio = '0; srcPrio[2*3 +: 3] = 3'd5;
    @(negedge clk);
    srcReq[2] = 1'b1; mPend[NT+2] = 1'b1;
    @(negedge clk);
    srcReq = '0;
    chk("R1", "irqReq after one edge", int'(irqReq), 0);
    @(negedge clk);
    checkOut("R1,R5,R6");
    chk("R1", "irqVec value", int'(irqVec), 5);
    chk("R6", "irqAddr value", int'(irqAddr), 14);
    drain();

    // R2: exhaustive level / priority / enable gating on two sources
    for (int si = 0; si < 2; si++) begin
      for (int en = 0; en < 2; en++) begin
        for (int p = 0; p < 8; p++) begin
          for (int l = 0; l < 8; l++) begin
            int s;
            s = (si == 0) ? 0 : NS - 1;
            srcEn = '0; srcEn[s] = en[0];
            srcPrio = '0; srcPrio[s*3 +: 3] = p[2:0];
            cpuLevel = l[2:0];
            applyReq(NS'(1) << s, '0, "R2");
            drain();
          end
        end
      end
    end

    // R4: traps ignore level and enables, outrank maskable
    srcEn = '0; cpuLevel = 3'd7;
    applyReq('0, 3'b100, "R4");
    chk("R4", "trap vec under level 7", int'(irqVec), 2);
    drain();
    srcEn = '1; srcPrio = {NS{3'd7}}; cpuLevel = 3'd6;
    applyReq(8'h01, 3'b010, "R4");
    chk("R4", "trap beats prio 7", int'(irqVec), 1);
    drain();

    // R7 sticky flag, R8 ack while idle ignored
    srcEn = '1; srcPrio = '0; srcPrio[1*3 +: 3] = 3'd3; cpuLevel = 3'd7;
    applyReq(8'h02, '0, "R2,R7");
    repeat (8) @(negedge clk);
    chk("R7", "ineligible stays quiet", int'(irqReq), 0);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    @(negedge clk);
    chk("R8", "idle ack no request", int'(irqReq), 0);
    cpuLevel = 3'd0;
    @(negedge clk);
    checkOut("R7,R8 flag survived");
    chk("R7", "sticky vec", int'(irqVec), NT + 1);
    drain();

    // R9: ack and re-request in the same cycle
    srcEn = '1; srcPrio = '0; srcPrio[4*3 +: 3] = 3'd6; cpuLevel = 3'd0;
    applyReq(8'h10, '0, "R9");
    ackOnce(1'b1, "R9 maskable re-request");
    chk("R9", "same vec after gap", int'(irqVec), NT + 4);
    applyReq('0, 3'b001, "R9");
    ackOnce(1'b1, "R9 trap re-request");
    chk("R9", "trap vec after gap", int'(irqVec), 0);
    ackOnce(1'b0, "R9 next winner");
    drain();

    // R3..R6: pseudo-random sweep with full acknowledge sequences
    for (int trial = 0; trial < 300; trial++) begin
      logic [NS-1:0] s;
      logic [NT-1:0] t;
      step(); srcEn = lfsr[NS-1:0];
      step(); srcPrio = lfsr[NS*3-1:0];
      step(); cpuLevel = lfsr[2:0];
      s = lfsr[10:3];
      t = (lfsr[12:11] == 2'b00) ? lfsr[15:13] : '0;
      applyReq(s, t, "R3,R4,R5,R6 sweep");
      for (int k = 0; k < TOT + 2; k++) begin
        if (!irqReq) break;
        ackOnce(1'b0, "R3,R4,R8 sweep ack");
      end
      drain();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule